// File: doc/BRIEF.md
# Pulse Width Capture Timer

This block measures how long a single input pin stays at a level, or how long one full period of that pin lasts, and reports the result as an 8-bit count of clock cycles. A three-flop chain brings the pin into the clock domain. Edges are found on the synchronized copy. A counter restarts on the edge that opens a measurement, and its value is latched on the edge that closes it.

Software reaches the block over a small register bus with three registers. The control register holds a 4-bit mode field that picks the kind of measurement. The status register holds two flags: one says that the data register holds a result nobody has read yet, and the other reports that the counter wrapped. The data register holds the most recent result that was accepted.

An unread result is protected from being overwritten. The one exception is the combined high-pulse-then-period mode, in which a new high-pulse result always replaces the old one.

Top module: `pwc_timer8`

## Requirements
- R1: After synchronous reset, the control register reads 0 (mode idle, 4'b0000), the status register reads 0 and the data register reads 0.
- R2: In mode 4'b0001 a measurement opens on a rising pin edge and closes on the next falling edge. With the count enable held high, a high pulse lasting N clock cycles stores N mod 256 in the data register.
- R3: In mode 4'b0010 a measurement opens on a falling edge and closes on the next rising edge. A low pulse of N cycles stores N.
- R4: In mode 4'b0011 each rising edge closes the running measurement and opens a new one. The stored result is the period (high time plus low time) in cycles.
- R5: Status bit 1 (buffer full) becomes 1 in the clock cycle after a result is written to the data register. A bus read of the data register (address 2) clears it. Writing the control register (address 0) clears the flag and restarts measurement.
- R6: While buffer full is 1, a newly finished result is discarded and the data register keeps its value.
- R7: In mode 4'b1001 a rising edge opens a measurement. The following falling edge stores the high time, and it does so even when buffer full is 1. The next rising edge stores the period, but only when buffer full is 0.
- R8: Status bit 1 reads 0 in any mode other than 4'b0001, 4'b0010, 4'b0011 and 4'b1001, and in those other modes no result is ever stored. Bus writes to status bit 1 are ignored.
- R9: In a measuring mode, when the counter increments past 8'hFF, status bit 0 (overflow) becomes 1 and the counter goes on counting from 0.
- R10: Writing status (address 1) with bit 0 at 0 clears overflow. Writing it with bit 0 at 1 leaves overflow unchanged.
- R11: A status read with the read-modify-write input high returns 1 in bit 0, whatever the value of overflow.
- R12: When a data read and a result write happen in the same cycle, the read returns the previous value and buffer full remains 1.
- R13: The counter advances only in cycles where the count enable input is high. The opening edge counts as the first cycle when the enable is high in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Counter advance enable |
| pin_in | input | 1 | Measured input, asynchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears buffer full on address 2) |
| bus_rmw | input | 1 | Marks a read as part of a read-modify-write |
| bus_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |

## Verification
The assertions assume that the pin is sampled only through the synchronizer. They also assume that strobes and data on the bus are stable around the rising clock edge, and that a single cycle carries at most one bus write. The bench drives the pin, the enable and every bus signal on the falling edge. It holds the pin at its idle level for several cycles before each mode write, so that no stale edge leaks into a new measurement. Pulse widths are kept well clear of the synchronizer depth except in the deliberate wrap case.

// File: rtl/pwc_timer8.sv
module pwc_timer8 (
  input  logic       clk,
  input  logic       rst,
  input  logic       cnt_en,
  input  logic       pin_in,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic       bus_rmw,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata
);

  localparam logic [3:0] M_IDLE = 4'b0000;
  localparam logic [3:0] M_HIGH = 4'b0001;
  localparam logic [3:0] M_LOW  = 4'b0010;
  localparam logic [3:0] M_PER  = 4'b0011;
  localparam logic [3:0] M_HP   = 4'b1001;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  logic [3:0] mode_q;
  logic [7:0] cnt_q, data_q;
  logic       full_q, ovf_q, armed_q, hi_done_q;
  logic [2:0] sync_q;

  logic start_ev, cap_hi, cap_end, force_wr;

  wire active  = (mode_q == M_HIGH) || (mode_q == M_LOW) ||
                 (mode_q == M_PER)  || (mode_q == M_HP);
  wire rise    = sync_q[1] & ~sync_q[2];
  wire fall    = ~sync_q[1] & sync_q[2];
  wire wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  wire wr_stat = bus_wr && (bus_addr == A_STAT);
  wire rd_data = bus_rd && (bus_addr == A_DATA);
  wire cap_any = cap_hi | cap_end;
  wire cap_wr  = cap_any & (~full_q | force_wr);
  wire wrap    = active & ~start_ev & cnt_en & (cnt_q == 8'hFF) & ~wr_ctrl;

  always_comb begin
    start_ev = 1'b0;
    cap_hi   = 1'b0;
    cap_end  = 1'b0;
    force_wr = 1'b0;
    case (mode_q)
      M_HIGH: begin start_ev = rise; cap_end = fall & armed_q; end
      M_LOW:  begin start_ev = fall; cap_end = rise & armed_q; end
      M_PER:  begin start_ev = rise; cap_end = rise & armed_q; end
      M_HP: begin
        start_ev = rise;
        cap_hi   = fall & armed_q & ~hi_done_q;
        cap_end  = rise & armed_q & hi_done_q;
        force_wr = cap_hi;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q    <= '0;
      mode_q    <= M_IDLE;
      cnt_q     <= '0;
      data_q    <= '0;
      full_q    <= 1'b0;
      ovf_q     <= 1'b0;
      armed_q   <= 1'b0;
      hi_done_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], pin_in};
      if (wrap)
        ovf_q <= 1'b1;
      else if (wr_stat && !bus_wdata[0])
        ovf_q <= 1'b0;
      if (wr_ctrl) begin
        mode_q    <= bus_wdata[3:0];
        cnt_q     <= '0;
        armed_q   <= 1'b0;
        hi_done_q <= 1'b0;
        full_q    <= 1'b0;
      end else begin
        if (!active)
          cnt_q <= '0;
        else if (start_ev)
          cnt_q <= cnt_en ? 8'd1 : 8'd0;
        else if (cnt_en)
          cnt_q <= cnt_q + 8'd1;

        if (!active)
          armed_q <= 1'b0;
        else if (start_ev)
          armed_q <= 1'b1;
        else if (cap_end && (mode_q == M_HIGH || mode_q == M_LOW))
          armed_q <= 1'b0;

        if (start_ev)
          hi_done_q <= 1'b0;
        else if (cap_hi)
          hi_done_q <= 1'b1;

        if (cap_wr)
          data_q <= cnt_q;

        if (!active)
          full_q <= 1'b0;
        else if (cap_wr)
          full_q <= 1'b1;
        else if (rd_data)
          full_q <= 1'b0;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {4'b0000, mode_q};
      A_STAT:  bus_rdata = {6'b000000, full_q & active, ovf_q | bus_rmw};
      A_DATA:  bus_rdata = data_q;
      default: bus_rdata = 8'h00;
    endcase
  end

  // R5
  cap_sets_full_chk: assert property (@(posedge clk) disable iff (rst)
    cap_wr && !wr_ctrl |=> full_q);

  // R5
  rd_clears_full_chk: assert property (@(posedge clk) disable iff (rst)
    rd_data && !cap_wr && !wr_ctrl |=> !full_q);

  // R6
  blocked_cap_chk: assert property (@(posedge clk) disable iff (rst)
    cap_any && full_q && !force_wr && !wr_ctrl |=> data_q == $past(data_q));

  // R7
  hp_override_chk: assert property (@(posedge clk) disable iff (rst)
    cap_hi && !wr_ctrl |=> full_q && data_q == $past(cnt_q));

  // R8
  idle_full_chk: assert property (@(posedge clk) disable iff (rst)
    bus_addr == A_STAT && !active |-> !bus_rdata[1]);

  // R9
  wrap_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> ovf_q && cnt_q == 8'h00);

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_q && !(wr_stat && !bus_wdata[0]) |=> ovf_q);

endmodule

// File: tb/pwc_timer8_tb_top.sv
`timescale 1ns/1ps
module pwc_timer8_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_en = 1'b1;
  logic       pin_in = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic       bus_rmw = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  pwc_timer8 dut_i (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .pin_in(pin_in),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rmw(bus_rmw),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  typedef struct packed {
    logic [3:0] mode;
    logic       idle;
    logic [9:0] w1;
    logic [9:0] w2;
    logic [9:0] w3;
    logic [7:0] exp;
    logic       ov;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{4'd1, 1'b0, 10'd12,  10'd7,   10'd5, 8'd12,  1'b0},
    '{4'd1, 1'b0, 10'd3,   10'd4,   10'd3, 8'd3,   1'b0},
    '{4'd2, 1'b1, 10'd9,   10'd6,   10'd4, 8'd9,   1'b0},
    '{4'd3, 1'b0, 10'd10,  10'd15,  10'd3, 8'd25,  1'b0},
    '{4'd9, 1'b0, 10'd8,   10'd11,  10'd6, 8'd6,   1'b0},
    '{4'd1, 1'b0, 10'd300, 10'd5,   10'd5, 8'd44,  1'b1},
    '{4'd3, 1'b0, 10'd100, 10'd100, 10'd2, 8'd200, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic rmw, output logic [7:0] v);
    bus_rd = 1'b1; bus_addr = a; bus_rmw = rmw;
    #1 v = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0; bus_rmw = 1'b0;
  endtask

  task automatic pulse(input logic idle, input int w1, input int w2, input int w3);
    pin_in = ~idle; hold(w1);
    pin_in = idle;  hold(w2);
    pin_in = ~idle; hold(w3);
    pin_in = idle;  hold(5);
  endtask

  function automatic string tag_of(input logic [3:0] m);
    case (m)
      4'd1:    return "R2 high pulse";
      4'd2:    return "R3 low pulse";
      4'd3:    return "R4 period";
      default: return "R7 combined";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] r, oldv;
    hold(3);
    rst = 1'b0;
    hold(1);
    rd(0, 0, r); chk("R1 ctrl reset", r, 8'h00);
    rd(1, 0, r); chk("R1 status reset", r, 8'h00);
    rd(2, 0, r); chk("R1 data reset", r, 8'h00);

    for (int i = 0; i < 7; i++) begin
      vec_t v;
      v = VECS[i];
      pin_in = v.idle; hold(4);
      wr(0, {4'b0000, v.mode});
      pulse(v.idle, int'(v.w1), int'(v.w2), int'(v.w3));
      rd(1, 0, r);
      chk("R5 full after capture", {7'd0, r[1]}, 8'd1);
      chk("R9 overflow flag", {7'd0, r[0]}, {7'd0, v.ov});
      rd(2, 0, r);
      chk(tag_of(v.mode), r, v.exp);
      rd(1, 0, r);
      chk("R5 full cleared by read", {7'd0, r[1]}, 8'd0);
      wr(1, 8'h00);
    end

    // R13 enable gating
    pin_in = 1'b0; hold(4);
    wr(0, 8'h01);
    pin_in = 1'b1; hold(5);
    cnt_en = 1'b0; hold(5);
    cnt_en = 1'b1; hold(10);
    pin_in = 1'b0; hold(5);
    rd(2, 0, r); chk("R13 enable gated count", r, 8'd15);

    // R12 simultaneous read and capture
    rd(2, 0, oldv);
    wr(0, 8'h01);
    pin_in = 1'b1; hold(10);
    pin_in = 1'b0; hold(2);
    rd(2, 0, r); chk("R12 read returns old value", r, oldv);
    rd(1, 0, r); chk("R12 full stays set", {7'd0, r[1]}, 8'd1);
    wr(1, 8'h01);
    rd(1, 0, r); chk("R8 write to full ignored (set)", {7'd0, r[1]}, 8'd1);
    rd(2, 0, r); chk("R12 new value stored", r, 8'd10);
    wr(1, 8'h02);
    rd(1, 0, r); chk("R8 write to full ignored (clear)", {7'd0, r[1]}, 8'd0);

    // R7 combined mode, high result read before the period ends
    pin_in = 1'b0; hold(4);
    wr(0, 8'h09);
    pin_in = 1'b1; hold(7);
    pin_in = 1'b0; hold(4);
    rd(2, 0, r); chk("R7 high result", r, 8'd7);
    hold(4);
    pin_in = 1'b1; hold(5);
    rd(2, 0, r); chk("R7 period stored after read", r, 8'd16);

    // R6 blocked capture in period mode
    pin_in = 1'b0; hold(4);
    wr(0, 8'h03);
    pin_in = 1'b1; hold(6); pin_in = 1'b0; hold(6);
    pin_in = 1'b1; hold(9); pin_in = 1'b0; hold(9);
    pin_in = 1'b1; hold(5);
    rd(2, 0, r); chk("R6 second result discarded", r, 8'd12);

    // R8 idle mode stores nothing
    wr(0, 8'h00);
    rd(2, 0, oldv);
    pulse(1'b0, 8, 8, 8);
    rd(1, 0, r); chk("R8 idle full reads 0", {7'd0, r[1]}, 8'd0);
    rd(2, 0, r); chk("R8 idle no capture", r, oldv);

    // R9 / R10 / R11 overflow flag handling
    pin_in = 1'b0; hold(4);
    wr(0, 8'h01);
    pin_in = 1'b1; hold(260); pin_in = 1'b0; hold(5);
    rd(1, 0, r); chk("R9 wrap sets overflow", {7'd0, r[0]}, 8'd1);
    rd(2, 0, r); chk("R9 counter keeps counting", r, 8'd4);
    wr(1, 8'h01);
    rd(1, 0, r); chk("R10 write 1 keeps overflow", {7'd0, r[0]}, 8'd1);
    wr(1, 8'h00);
    rd(1, 0, r); chk("R10 write 0 clears overflow", {7'd0, r[0]}, 8'd0);
    rd(1, 1, r); chk("R11 rmw read returns 1", {7'd0, r[0]}, 8'd1);
    rd(1, 0, r); chk("R11 flag still clear", {7'd0, r[0]}, 8'd0);

    // R1 reset mid-run
    rst = 1'b1; hold(2); rst = 1'b0; hold(1);
    rd(0, 0, r); chk("R1 ctrl after reset", r, 8'h00);
    rd(2, 0, r); chk("R1 data after reset", r, 8'h00);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule